// File: doc/BRIEF.md
# Dual-Channel DAC Write Front End

This block is the digital input stage of a two-channel, 12-bit digital-to-analog converter. A single 12-bit parallel bus feeds both channels. Each channel has its own active-low select, and both share one active-low write strobe. A channel captures the bus when its write cycle closes. The cycle closes on whichever of the two strobes (its select or the shared write) rises first while the other is still low. When both selects are low as the write strobe rises, both channels capture the same word in the same cycle.

The strobes come from outside the clock domain. Each one passes through a two-flop synchroniser, and all decisions are taken on the synchronised levels. Each channel runs a two-state machine. In `CH_IDLE`, the transition *open* fires when the synchronised select and write are both low, and the machine moves to `CH_ARMED`. In `CH_ARMED`, the transition *close* fires as soon as either strobe reads high. It returns the machine to `CH_IDLE` and pulses a load that copies a registered sample of the bus into the channel's held code. If neither condition holds, the machine stays in its current state.

The held code of each channel is decoded into switch controls for a segmented converter. The upper two bits drive three equal-weight thermometer lines, and each line stands for one quarter of full scale. The lower ten bits drive ten binary-weighted lines directly. Code 0 turns every line off. Code 4095 corresponds to 4095/4096 of full scale.

Top module: `dual_dac_front`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, both held codes clear to 0, and every thermometer and binary line is 0.
- R2: Channel A loads the bus only at the close of a write cycle in which `sel_a_n` and `wr_n` were both low. `code_a` then equals the bus word, and `code_b` is untouched when `sel_b_n` stayed high.
- R3: Channel B loads in the same way under `sel_b_n`. `code_a` is untouched when `sel_a_n` stayed high.
- R4: A write cycle closed by `wr_n` rising while the select is still low loads that channel.
- R5: A write cycle closed by the select rising while `wr_n` is still low loads that channel. A later rise of `wr_n` with the select high loads nothing.
- R6: If both selects are low when the write cycle closes, both channels capture the same bus word.
- R7: While `wr_n` stays high, toggling the selects and the bus changes neither code.
- R8: While both selects stay high, toggling `wr_n` and the bus changes neither code.
- R9: Thermometer lines `therm_x[2:0]`, with bit 0 the lowest-weight line, follow the code's top two bits: 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111.
- R10: Binary lines `bin_x[9:0]` equal the code's bits 9..0, and line i carries weight 2^i.
- R11: The code changes at the third rising clock edge after the closing strobe edge, and not before. The bus must hold its value through the second of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Shared write strobe, active low, asynchronous |
| sel_a_n | input | 1 | Channel A select, active low, asynchronous |
| sel_b_n | input | 1 | Channel B select, active low, asynchronous |
| data_in | input | 12 | Shared data bus |
| code_a | output | 12 | Held code of channel A |
| code_b | output | 12 | Held code of channel B |
| therm_a | output | 3 | Channel A thermometer steering lines |
| bin_a | output | 10 | Channel A binary ladder lines |
| therm_b | output | 3 | Channel B thermometer steering lines |
| bin_b | output | 10 | Channel B binary ladder lines |

## Verification
The bench closes write cycles both ways: by the write strobe and by the select. A design that reacted only to the write edge would miss the select-closed cycles, and one that reacted to the select would load twice or at the wrong time. Words are driven with both selects low, to catch a design that gives only one channel priority. The bus is inverted right after each cycle, so a latch that tracks the bus instead of holding is exposed. The bench also toggles one strobe while the other is held high and expects no transfer; a gate that used OR in place of AND would load here. It measures the exact load edge, and it hits every top-bit pair in the decoder, so an off-by-one thermometer fill or a swapped segment would show.

// File: rtl/ddac_pkg.sv
package ddac_pkg;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_ARMED = 1'b1
    } ch_state_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_n,
    output logic [N-1:0] level_n
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= async_n;
            stage2 <= stage1;
        end
    end

    assign level_n = stage2;
endmodule

// File: rtl/chan_latch.sv
module chan_latch
    import ddac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_lvl_n,
    input  logic              wr_lvl_n,
    input  logic [DATA_W-1:0] bus_q,
    output logic [DATA_W-1:0] code
);
    ch_state_t state;
    ch_state_t state_nx;
    logic      both_low;
    logic      load;

    assign both_low = !sel_lvl_n && !wr_lvl_n;

    always_ff @(posedge clk) begin
        if (rst) state <= CH_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            CH_IDLE: begin
                if (both_low) state_nx = CH_ARMED;
            end
            CH_ARMED: begin
                if (!both_low) begin
                    state_nx = CH_IDLE;
                    load     = 1'b1;
                end
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (load) code <= bus_q;
    end
endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
    parameter int DATA_W   = 12,
    parameter int SEG_BITS = 2,
    localparam int THERM_W = (1 << SEG_BITS) - 1,
    localparam int BIN_W   = DATA_W - SEG_BITS
) (
    input  logic [DATA_W-1:0]  code,
    output logic [THERM_W-1:0] therm,
    output logic [BIN_W-1:0]   bin
);
    logic [SEG_BITS-1:0] top;
    assign top = code[DATA_W-1 -: SEG_BITS];
    assign bin = code[BIN_W-1:0];

    for (genvar i = 0; i < THERM_W; i++) begin : g_line
        assign therm[i] = (int'(top) > i);
    end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
    parameter int DATA_W   = 12,
    parameter int SEG_BITS = 2,
    localparam int THERM_W = (1 << SEG_BITS) - 1,
    localparam int BIN_W   = DATA_W - SEG_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_n,
    input  logic               sel_a_n,
    input  logic               sel_b_n,
    input  logic [DATA_W-1:0]  data_in,
    output logic [DATA_W-1:0]  code_a,
    output logic [DATA_W-1:0]  code_b,
    output logic [THERM_W-1:0] therm_a,
    output logic [BIN_W-1:0]   bin_a,
    output logic [THERM_W-1:0] therm_b,
    output logic [BIN_W-1:0]   bin_b
);
    localparam int NCH = 2;

    logic [NCH:0]       lvl_n;
    logic [DATA_W-1:0]  bus_q;
    logic [DATA_W-1:0]  code_arr  [NCH];
    logic [THERM_W-1:0] therm_arr [NCH];
    logic [BIN_W-1:0]   bin_arr   [NCH];

    strobe_sync #(.N(NCH + 1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n ({sel_b_n, sel_a_n, wr_n}),
        .level_n (lvl_n)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= data_in;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_latch #(.DATA_W(DATA_W)) u_latch (
            .clk       (clk),
            .rst       (rst),
            .sel_lvl_n (lvl_n[c + 1]),
            .wr_lvl_n  (lvl_n[0]),
            .bus_q     (bus_q),
            .code      (code_arr[c])
        );

        seg_decode #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_dec (
            .code  (code_arr[c]),
            .therm (therm_arr[c]),
            .bin   (bin_arr[c])
        );
    end

    assign code_a  = code_arr[0];
    assign code_b  = code_arr[1];
    assign therm_a = therm_arr[0];
    assign therm_b = therm_arr[1];
    assign bin_a   = bin_arr[0];
    assign bin_b   = bin_arr[1];
endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
    parameter int DATA_W   = 12,
    parameter int SEG_BITS = 2,
    localparam int THERM_W = (1 << SEG_BITS) - 1,
    localparam int BIN_W   = DATA_W - SEG_BITS
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_n,
    input logic               sel_a_n,
    input logic               sel_b_n,
    input logic [DATA_W-1:0]  code_a,
    input logic [DATA_W-1:0]  code_b,
    input logic [THERM_W-1:0] therm_a,
    input logic [BIN_W-1:0]   bin_a,
    input logic [THERM_W-1:0] therm_b,
    input logic [BIN_W-1:0]   bin_b
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (code_a == '0) && (code_b == '0));

    p_quiet_a_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && $past(sel_a_n) && $past(sel_a_n, 2) && $past(sel_a_n, 3)
         && $past(sel_a_n, 4) && !$past(rst)) |-> $stable(code_a));

    p_quiet_b_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_b_n && $past(sel_b_n) && $past(sel_b_n, 2) && $past(sel_b_n, 3)
         && $past(sel_b_n, 4) && !$past(rst)) |-> $stable(code_b));

    p_wr_high_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_n && $past(wr_n) && $past(wr_n, 2) && $past(wr_n, 3)
         && $past(wr_n, 4) && !$past(rst)) |-> ($stable(code_a) && $stable(code_b)));

    p_therm_fill_r9: assert property (@(posedge clk) disable iff (rst)
        ($countones(therm_a) == int'(code_a[DATA_W-1 -: SEG_BITS]))
        && ($countones(therm_b) == int'(code_b[DATA_W-1 -: SEG_BITS]))
        && !therm_a[THERM_W-1:1] == !therm_a[THERM_W-2:0] || therm_a[0]);

    p_bin_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (bin_a == code_a[BIN_W-1:0]) && (bin_b == code_b[BIN_W-1:0]));
endmodule

bind dual_dac_front dual_dac_front_chk #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_n    (wr_n),
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n),
    .code_a  (code_a),
    .code_b  (code_b),
    .therm_a (therm_a),
    .bin_a   (bin_a),
    .therm_b (therm_b),
    .bin_b   (bin_b)
);

// File: tb/sim_dual_dac_front.sv
`timescale 1ns/1ps
module sim_dual_dac_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic        sel_a_n = 1'b1;
    logic        sel_b_n = 1'b1;
    logic [11:0] data_in = 12'h000;
    logic [11:0] code_a, code_b;
    logic [2:0]  therm_a, therm_b;
    logic [9:0]  bin_a, bin_b;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [11:0] exp_a = 12'h000;
    logic [11:0] exp_b = 12'h000;

    always #2 clk = ~clk;

    dual_dac_front u0 (
        .clk(clk), .rst(rst), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .data_in(data_in), .code_a(code_a), .code_b(code_b),
        .therm_a(therm_a), .bin_a(bin_a), .therm_b(therm_b), .bin_b(bin_b)
    );

    // {close_by_select, select mask {B,A}, data word}
    localparam logic [14:0] VEC [0:7] = '{
        {1'b0, 2'b01, 12'hABC},
        {1'b0, 2'b10, 12'h123},
        {1'b0, 2'b11, 12'hFFF},
        {1'b1, 2'b01, 12'h400},
        {1'b1, 2'b10, 12'h800},
        {1'b1, 2'b11, 12'h3FF},
        {1'b0, 2'b01, 12'hC01},
        {1'b0, 2'b10, 12'h000}
    };

    function automatic logic [2:0] exp_therm(input logic [11:0] c);
        case (c[11:10])
            2'b00:   return 3'b000;
            2'b01:   return 3'b001;
            2'b10:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " R2 code_a"}, code_a, exp_a);
        check({req, " R3 code_b"}, code_b, exp_b);
        check("R9 therm_a", {9'd0, therm_a}, {9'd0, exp_therm(exp_a)});
        check("R9 therm_b", {9'd0, therm_b}, {9'd0, exp_therm(exp_b)});
        check("R10 bin_a", {2'd0, bin_a}, {2'd0, exp_a[9:0]});
        check("R10 bin_b", {2'd0, bin_b}, {2'd0, exp_b[9:0]});
    endtask

    task automatic do_write(input bit by_sel, input logic [1:0] mask, input logic [11:0] d);
        @(negedge clk);
        data_in = d;
        sel_a_n = !mask[0];
        sel_b_n = !mask[1];
        @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        if (!by_sel) wr_n = 1'b1;
        else begin
            if (mask[0]) sel_a_n = 1'b1;
            if (mask[1]) sel_b_n = 1'b1;
        end
        repeat (5) @(negedge clk);
        wr_n = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1;
        data_in = ~d;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        for (int i = 0; i < 8; i++) begin
            if (VEC[i][12]) exp_a = VEC[i][11:0];
            if (VEC[i][13]) exp_b = VEC[i][11:0];
            do_write(VEC[i][14], VEC[i][13:12], VEC[i][11:0]);
            if (VEC[i][13:12] == 2'b11) check_all(VEC[i][14] ? "R6 R5" : "R6 R4");
            else                        check_all(VEC[i][14] ? "R5" : "R4");
        end

        // R7: write strobe held high
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            sel_a_n = k[0]; sel_b_n = k[1]; data_in = 12'h5A5 ^ 12'(k);
            repeat (3) @(negedge clk);
        end
        sel_a_n = 1'b1; sel_b_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R7");

        // R8: both selects held high
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_n = k[0]; data_in = 12'h9C3 + 12'(k);
            repeat (3) @(negedge clk);
        end
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R8");

        // R11: exact load edge
        @(negedge clk);
        data_in = 12'h6E7; sel_a_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 before third edge", code_a, exp_a);
        @(posedge clk); @(negedge clk);
        exp_a = 12'h6E7;
        check("R11 at third edge", code_a, exp_a);
        sel_a_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset after data
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_a = 12'h000; exp_b = 12'h000;
        @(negedge clk);
        check_all("R1 re-reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule